// File: doc/BRIEF.md
# Address-Filtering UART Receiver

This block is an asynchronous serial receiver for a shared multi-drop line. One master talks to several listeners. The master precedes each burst of payload characters with an address character. Each character is marked by a frame-type bit as either address (1) or data (0). In 9-bit characters the ninth data bit carries that mark. In 5- to 8-bit characters the first stop bit carries it.

The line is oversampled at 16 times the bit rate, using a clock-enable pulse supplied from outside. When `filt_en` is high, data characters are dropped before they reach the one-entry holding register. Only address characters wake the host. The host checks the address. It then lowers `filt_en` to receive the payload that follows, and raises it again when the burst is over.

Received characters leave through a valid/ready port. The holding register presents a character with `out_valid` high. It keeps `out_data`, `out_is_addr` and `out_ferr` unchanged until a clock edge sees `out_ready` high. That edge empties the register. The receiver cannot be stalled. A character that arrives while the register is still full is lost, and the loss is flagged.

Top module: `addr_filter_uart_rx`

## Requirements
- R1: Each bit is decided by a majority vote of oversamples 7, 8 and 9 of 16. Data bits arrive LSB first. The character size `cfg_char_bits` ranges from 5 to 9; values below 5 act as 5 and values above 9 act as 9. The character is right-aligned in `out_data`, and the unused upper bits read 0.
- R2: A start bit counts only if the vote at its middle is low. Otherwise the receiver returns to idle and delivers nothing.
- R3: The frame-type bit is taken from the ninth data bit in 9-bit mode, and from the first stop bit in 5- to 8-bit mode. A value of 1 means address; it appears on `out_is_addr`.
- R4: With `filt_en` low, every character, address or data, is delivered with its frame-type bit.
- R5: With `filt_en` high, a data character changes no output. An address character is delivered exactly as it would be unfiltered.
- R6: A delivered character raises `out_valid`. `out_valid`, `out_data`, `out_is_addr` and `out_ferr` hold steady until a clock edge with `out_ready` high. After that edge, `out_valid` falls unless a new character is stored in the same edge.
- R7: `out_ferr` is 1 in the following cases. In 9-bit mode, any stop bit is sampled low. In 5- to 8-bit mode, two stop bits are used (`cfg_two_stop`=1) and the second is sampled low. In 5- to 8-bit mode, the first stop bit never causes a framing error.
- R8: A character accepted while `out_valid` is high and not being emptied sets `err_overrun`, and the stored character is kept. `err_overrun` clears at the next emptying edge. If a character arrives on an emptying edge, it is stored with no overrun.
- R9: After reset, `out_valid`, `err_overrun`, `out_ferr` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_x16_tick | input | 1 | One-cycle enable, 16 per bit time |
| rxd | input | 1 | Serial line, idles high |
| cfg_char_bits | input | 4 | Character size, 5 to 9 |
| cfg_two_stop | input | 1 | 1: two stop bits expected |
| filt_en | input | 1 | 1: drop data characters |
| out_valid | output | 1 | Holding register full |
| out_ready | input | 1 | Host takes the character |
| out_data | output | 9 | Received character, right-aligned |
| out_is_addr | output | 1 | Frame-type bit of the character |
| out_ferr | output | 1 | Framing error of the character |
| err_overrun | output | 1 | A character was lost while full |

## Verification
Some faults live in the bit counter or the frame-type select. A miscounted bit index or a wrong type select shows up at the end of the very next character as a shifted value, a wrong `out_is_addr`, or a character passed or dropped against the filter rule.

A sampler whose phase is off corrupts characters only when the line changes near the vote point. The bench therefore uses patterns with isolated ones and zeros.

Some faults sit in the holding register or the overrun flag. They appear only when the host stalls, on the first character that lands while the register is full. The bench provokes this on purpose.

// File: rtl/uafr_pkg.sv
package uafr_pkg;
  localparam int CHAR_MAX = 9;
  localparam int CHAR_MIN = 5;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP1, RX_STOP2
  } rx_state_t;

  typedef struct packed {
    logic [CHAR_MAX-1:0] data;
    logic                is_addr;
    logic                ferr;
  } rx_char_t;
endpackage

// File: rtl/uafr_sync.sv
module uafr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uafr_sampler.sv
module uafr_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic busy,
  output logic vote_stb,
  output logic vote_val
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [CW-1:0] cnt;
  logic          s_a, s_b;
  logic          maj;

  assign maj = (s_a & s_b) | (s_a & line) | (s_b & line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      s_a      <= 1'b1;
      s_b      <= 1'b1;
      vote_stb <= 1'b0;
      vote_val <= 1'b1;
    end else begin
      vote_stb <= 1'b0;
      if (!busy) begin
        cnt <= (tick && !line) ? CW'(1) : '0;
      end else if (tick) begin
        cnt <= (cnt == CW'(OSR-1)) ? '0 : cnt + CW'(1);
        if (cnt == CW'(MID-1)) s_a <= line;
        if (cnt == CW'(MID))   s_b <= line;
        if (cnt == CW'(MID+1)) begin
          vote_stb <= 1'b1;
          vote_val <= maj;
        end
      end
    end
  end
endmodule

// File: rtl/uafr_framer.sv
module uafr_framer
  import uafr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       vote_stb,
  input  logic       vote_val,
  input  logic [3:0] cfg_char_bits,
  input  logic       cfg_two_stop,
  output logic       busy,
  output logic       char_done,
  output rx_char_t   char_q
);
  localparam int IW = $clog2(CHAR_MAX + 1);

  rx_state_t           state;
  logic [CHAR_MAX-1:0] shreg;
  logic [IW-1:0]       idx;
  logic                stop1_q;
  logic [3:0]          nbits;

  always_comb begin
    if (cfg_char_bits < 4'(CHAR_MIN))      nbits = 4'(CHAR_MIN);
    else if (cfg_char_bits > 4'(CHAR_MAX)) nbits = 4'(CHAR_MAX);
    else                                   nbits = cfg_char_bits;
  end

  function automatic rx_char_t build(input logic [CHAR_MAX-1:0] sh,
                                     input logic [3:0] n,
                                     input logic s1, input logic s2,
                                     input logic two);
    rx_char_t r;
    r.data = sh >> (4'(CHAR_MAX) - n);
    if (n == 4'(CHAR_MAX)) begin
      r.is_addr = r.data[CHAR_MAX-1];
      r.ferr    = !s1 || (two && !s2);
    end else begin
      r.is_addr = s1;
      r.ferr    = two && !s2;
    end
    return r;
  endfunction

  assign busy = (state != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      shreg     <= '0;
      idx       <= '0;
      stop1_q   <= 1'b1;
      char_done <= 1'b0;
      char_q    <= '0;
    end else begin
      char_done <= 1'b0;
      unique case (state)
        RX_IDLE: if (tick && !line) state <= RX_START;
        RX_START: if (vote_stb) begin
          if (vote_val) state <= RX_IDLE;
          else begin
            state <= RX_DATA;
            idx   <= '0;
            shreg <= '0;
          end
        end
        RX_DATA: if (vote_stb) begin
          shreg <= {vote_val, shreg[CHAR_MAX-1:1]};
          if (idx == IW'(nbits - 4'd1)) state <= RX_STOP1;
          else                          idx   <= idx + IW'(1);
        end
        RX_STOP1: if (vote_stb) begin
          stop1_q <= vote_val;
          if (cfg_two_stop) state <= RX_STOP2;
          else begin
            state     <= RX_IDLE;
            char_done <= 1'b1;
            char_q    <= build(shreg, nbits, vote_val, 1'b1, 1'b0);
          end
        end
        RX_STOP2: if (vote_stb) begin
          state     <= RX_IDLE;
          char_done <= 1'b1;
          char_q    <= build(shreg, nbits, stop1_q, vote_val, 1'b1);
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uafr_holding.sv
module uafr_holding
  import uafr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                char_done,
  input  rx_char_t            char_in,
  input  logic                filt_en,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [CHAR_MAX-1:0] out_data,
  output logic                out_is_addr,
  output logic                out_ferr,
  output logic                err_overrun
);
  logic accept, pop;

  assign accept = char_done && (!filt_en || char_in.is_addr);
  assign pop    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_addr <= 1'b0;
      out_ferr    <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (accept && (!out_valid || pop)) begin
        out_valid   <= 1'b1;
        out_data    <= char_in.data;
        out_is_addr <= char_in.is_addr;
        out_ferr    <= char_in.ferr;
      end else if (pop) begin
        out_valid <= 1'b0;
      end
      if (accept && out_valid && !pop) err_overrun <= 1'b1;
      else if (pop)                    err_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_filter_uart_rx.sv
module addr_filter_uart_rx
  import uafr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_x16_tick,
  input  logic                rxd,
  input  logic [3:0]          cfg_char_bits,
  input  logic                cfg_two_stop,
  input  logic                filt_en,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CHAR_MAX-1:0] out_data,
  output logic                out_is_addr,
  output logic                out_ferr,
  output logic                err_overrun
);
  logic     line_s, busy, vote_stb, vote_val, char_done;
  rx_char_t char_q;

  uafr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s));

  uafr_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(baud_x16_tick), .line(line_s),
    .busy(busy), .vote_stb(vote_stb), .vote_val(vote_val));

  uafr_framer u_frm (
    .clk(clk), .rst_n(rst_n), .tick(baud_x16_tick), .line(line_s),
    .vote_stb(vote_stb), .vote_val(vote_val),
    .cfg_char_bits(cfg_char_bits), .cfg_two_stop(cfg_two_stop),
    .busy(busy), .char_done(char_done), .char_q(char_q));

  uafr_holding u_hold (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_in(char_q),
    .filt_en(filt_en), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_is_addr(out_is_addr), .out_ferr(out_ferr),
    .err_overrun(err_overrun));
endmodule

// File: rtl/uafr_checker.sv
module uafr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       filt_en,
  input logic       out_valid,
  input logic       out_ready,
  input logic [8:0] out_data,
  input logic       out_is_addr,
  input logic       err_overrun,
  input logic       char_done,
  input logic       char_is_addr
);
  // R6: a stalled character stays presented
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  assert_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_is_addr));
  assert_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !char_done |=> !out_valid);
  // R5: filtered data characters never fill the register
  assert_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && filt_en && !char_is_addr && !out_valid |=> !out_valid);
  // R8: overrun only while full, and the stored character survives
  assert_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(out_valid) && $stable(out_data));
endmodule

bind addr_filter_uart_rx uafr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_is_addr(out_is_addr),
  .err_overrun(err_overrun), .char_done(char_done),
  .char_is_addr(char_q.is_addr));

// File: tb/sim_addr_filter_uart_rx.sv
module sim_addr_filter_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [3:0] cfg_bits = 4'd8;
  logic       two_stop = 1'b0;
  logic       filt = 1'b0;
  logic       ready = 1'b1;
  logic       out_valid, out_is_addr, out_ferr, err_overrun;
  logic [8:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [10:0] expq[$];
  logic [1:0]  tdiv = 2'd0;

  always #5 clk = ~clk;
  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  addr_filter_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .baud_x16_tick(tick), .rxd(rxd),
    .cfg_char_bits(cfg_bits), .cfg_two_stop(two_stop), .filt_en(filt),
    .out_valid(out_valid), .out_ready(ready), .out_data(out_data),
    .out_is_addr(out_is_addr), .out_ferr(out_ferr), .err_overrun(err_overrun));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  // Drive one character; push the expected result when the rules say it is kept
  task automatic send(input int n, input logic [8:0] d, input logic s1,
                      input logic s2, input bit push);
    logic [8:0]  m;
    logic        typ, fe;
    int          nn;
    nn  = (n < 5) ? 5 : (n > 9) ? 9 : n;
    m   = d & 9'((1 << nn) - 1);
    typ = (nn == 9) ? m[8] : s1;
    fe  = (nn == 9) ? (!s1 || (two_stop && !s2)) : (two_stop && !s2);
    if (push && (!filt || typ)) expq.push_back({m, typ, fe});
    bit_time(1'b0);
    for (int i = 0; i < nn; i++) bit_time(d[i]);
    bit_time(s1);
    if (two_stop) bit_time(s2);
    rxd = 1'b1;
    repeat (2 * 64) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && ready) begin
      if (expq.size() == 0) begin
        check("R5 unexpected character", {5'd0, out_data, out_is_addr, out_ferr}, 16'hFFFF);
      end else begin
        logic [10:0] e;
        e = expq.pop_front();
        check("R1/R3/R4/R7 character", {5'd0, out_data, out_is_addr, out_ferr}, {5'd0, e});
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 valid", 16'(out_valid), 16'd0);
    check("R9 overrun", 16'(err_overrun), 16'd0);
    check("R9 data", 16'(out_data), 16'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R4, R3: unfiltered, 8-bit, data and address
    send(8, 9'h0A5, 1'b0, 1'b1, 1);
    send(8, 9'h03C, 1'b1, 1'b1, 1);
    // R1: 5-bit and 7-bit, upper bits zero, clamps
    cfg_bits = 4'd5; send(5, 9'h1F5, 1'b1, 1'b1, 1);
    cfg_bits = 4'd7; send(7, 9'h055, 1'b0, 1'b1, 1);
    cfg_bits = 4'd2; send(2, 9'h013, 1'b0, 1'b1, 1);
    // R3: 9-bit, type from ninth bit
    cfg_bits = 4'd9; send(9, 9'h1A2, 1'b1, 1'b1, 1);
    send(9, 9'h0B7, 1'b1, 1'b1, 1);
    // R7: framing
    send(9, 9'h101, 1'b0, 1'b1, 1);
    cfg_bits = 4'd8; two_stop = 1'b1;
    send(8, 9'h081, 1'b0, 1'b1, 1);
    send(8, 9'h042, 1'b1, 1'b0, 1);
    two_stop = 1'b0;
    // R5: filter on, data dropped, address kept
    filt = 1'b1;
    send(8, 9'h011, 1'b0, 1'b1, 1);
    check("R5 dropped data leaves no character", 16'(out_valid), 16'd0);
    send(8, 9'h022, 1'b1, 1'b1, 1);
    cfg_bits = 4'd9;
    send(9, 9'h033, 1'b1, 1'b1, 1);
    check("R5 dropped 9-bit data", 16'(out_valid), 16'd0);
    send(9, 9'h144, 1'b1, 1'b1, 1);
    filt = 1'b0; cfg_bits = 4'd8;

    // R2: false start glitch
    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (40 * 64) @(negedge clk);
    check("R2 glitch delivers nothing", 16'(out_valid), 16'd0);
    send(8, 9'h0C3, 1'b0, 1'b1, 1);

    // R8, R6: stalled host
    ready = 1'b0;
    send(8, 9'h05A, 1'b1, 1'b1, 1);
    check("R6 held valid", 16'(out_valid), 16'd1);
    check("R8 no overrun yet", 16'(err_overrun), 16'd0);
    send(8, 9'h0FF, 1'b0, 1'b1, 0);
    check("R8 overrun set", 16'(err_overrun), 16'd1);
    check("R8 first kept", 16'(out_data), 16'h05A);
    check("R6 type kept", 16'(out_is_addr), 16'd1);
    ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 overrun cleared", 16'(err_overrun), 16'd0);
    check("R6 emptied", 16'(out_valid), 16'd0);

    repeat (200) @(negedge clk);
    check("R4 all expected characters seen", 16'(expq.size()), 16'd0);
    finish_run();
  end
endmodule